// File: doc/BRIEF.md
# Compare-Driven Toggle PWM Generator

This block makes a pulse-width-modulated waveform from one free-running 16-bit timer and one compare register. It does not compare against a threshold. Each time the timer reaches the compare value, the output flips and a one-clock event pulse is raised. A short service sequence then pushes the compare value forward by one of two programmed increments and inverts a toggle bit. That bit picks the increment for the next service, so the two increments alternate and set the high time and the low time of the waveform.

Software programs four things:
- the two increments (`inc_lo` for the on-time, `inc_hi` for the off-time);
- the first compare value;
- a control word: a 3-bit mode field, a toggle-mode select bit and the initial toggle value.

Generation runs only while the timer is enabled and the control word selects toggle PWM. The live toggle bit can be read back at all times. All arithmetic wraps modulo 2^16, so periods continue unchanged across timer overflow.

The service sequence is a three-state machine:
- `ST_IDLE` waits for a match. Transition *hit*: IDLE to ADVANCE.
- `ST_ADVANCE` adds the chosen increment to the compare register. Transition *added*: ADVANCE to FLIP, taken unconditionally.
- `ST_FLIP` inverts the toggle bit. Transition *done*: FLIP to IDLE, taken unconditionally.

Matches are not detected while the machine is busy. For this reason both increments must be at least 3 clocks.

Top module: `cmp_toggle_pwm`

## Requirements
- R1: While generation runs, a match occurs in the cycle in which the timer equals the compare register. One clock later, `pwm_out` has inverted and `match_evt` is high for exactly that one cycle. `pwm_out` never changes in a cycle where `match_evt` is low.
- R2: Each match advances the compare register by `inc_lo` when the toggle bit is 0, or by `inc_hi` when it is 1. The sum wraps modulo 2^16.
- R3: The toggle bit inverts once per match. The new value is visible on `tbit_live` two clocks after the `match_evt` cycle. `tbit_live` always shows the live bit, not the configured initial value.
- R4: Synchronous active-high `rst` has these effects:
  - `pwm_out` becomes 1.
  - The timer becomes 0.
  - The toggle bit is loaded from `ctl_tbit_init`.
  - The compare register is loaded from `cmp_start`.
  - `match_evt` becomes 0.
- R5: The timer starts at 0 in the first enabled cycle after reset. The first `match_evt` appears `cmp_start`+1 clocks after that cycle, and the first match drives the output low.
- R6: When the initial toggle bit is 1, the time from one event to the next is `inc_hi`, then `inc_lo`, repeating. The output is low for `inc_hi` clocks and high for `inc_lo` clocks.
- R7: When the initial toggle bit is 0, the order is reversed. The low time is `inc_lo` and the high time is `inc_hi`.
- R8: Generation runs only when `ctl_mode` equals 3'b010 and `ctl_tgl_sel` is 1. Otherwise no `match_evt` occurs and `pwm_out` holds.
- R9: While `tmr_en` is low, the timer holds its count, no `match_evt` occurs, and `pwm_out` keeps its value. Clocks spent disabled lengthen the current interval by exactly their number.
- R10: Periods stay correct when the compare value or the timer wraps past 16'hFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tmr_en | input | 1 | Timer count enable |
| ctl_mode | input | 3 | Mode field; 3'b010 selects PWM |
| ctl_tgl_sel | input | 1 | 1 selects toggle mode |
| ctl_tbit_init | input | 1 | Toggle bit value loaded at reset |
| cmp_start | input | 16 | First compare value, loaded at reset |
| inc_lo | input | 16 | Increment added when the toggle bit is 0 (on-time) |
| inc_hi | input | 16 | Increment added when the toggle bit is 1 (off-time) |
| tbit_live | output | 1 | Live toggle bit |
| pwm_out | output | 1 | PWM waveform |
| match_evt | output | 1 | One-clock pulse on each match |

## Verification
The bench builds the block with its default 16-bit timer width. At this width, a first compare value of 16'hFFF0 lets the timer and the compare register both wrap within about 65,000 clocks. This puts the overflow behaviour within reach of a short run.

The bench also drives:
- increments at the minimum of 3;
- both initial toggle values;
- a disable window in the middle of a period, so that the stretched interval can be measured exactly.

// File: rtl/ctpwm_pkg.sv
package ctpwm_pkg;

    localparam int unsigned MODE_W = 3;
    localparam logic [MODE_W-1:0] MODE_PWM = 3'b010;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ADVANCE = 2'd1,
        ST_FLIP    = 2'd2
    } svc_state_t;

endpackage

// File: rtl/ctpwm_timer.sv
module ctpwm_timer #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    output logic [CNT_W-1:0] cnt
);

    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (en) begin
            cnt <= cnt + ONE;
        end
    end

endmodule

// File: rtl/ctpwm_svc_fsm.sv
module ctpwm_svc_fsm
    import ctpwm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       hit,
    output logic       ld_cmp,
    output logic       flip_tbit,
    output logic       busy,
    output svc_state_t state
);

    svc_state_t state_nx;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx  = state;
        ld_cmp    = 1'b0;
        flip_tbit = 1'b0;
        busy      = 1'b1;
        unique case (state)
            ST_IDLE: begin
                busy = 1'b0;
                if (hit) begin
                    state_nx = ST_ADVANCE;
                end
            end
            ST_ADVANCE: begin
                ld_cmp   = 1'b1;
                state_nx = ST_FLIP;
            end
            ST_FLIP: begin
                flip_tbit = 1'b1;
                state_nx  = ST_IDLE;
            end
            default: begin
                state_nx = ST_IDLE;
            end
        endcase
    end

endmodule

// File: rtl/ctpwm_cmp_path.sv
module ctpwm_cmp_path #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             busy,
    input  logic             ld_cmp,
    input  logic             flip_tbit,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] cmp_start,
    input  logic [CNT_W-1:0] inc_lo,
    input  logic [CNT_W-1:0] inc_hi,
    input  logic             tbit_init,
    output logic             hit,
    output logic             tbit,
    output logic [CNT_W-1:0] cmp
);

    logic [CNT_W-1:0] step;

    assign step = tbit ? inc_hi : inc_lo;
    assign hit  = run && !busy && (cnt == cmp);

    always_ff @(posedge clk) begin
        if (rst) begin
            cmp <= cmp_start;
        end else if (ld_cmp) begin
            cmp <= cmp + step;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tbit <= tbit_init;
        end else if (flip_tbit) begin
            tbit <= ~tbit;
        end
    end

endmodule

// File: rtl/cmp_toggle_pwm.sv
module cmp_toggle_pwm
    import ctpwm_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tmr_en,
    input  logic [MODE_W-1:0] ctl_mode,
    input  logic              ctl_tgl_sel,
    input  logic              ctl_tbit_init,
    input  logic [CNT_W-1:0]  cmp_start,
    input  logic [CNT_W-1:0]  inc_lo,
    input  logic [CNT_W-1:0]  inc_hi,
    output logic              tbit_live,
    output logic              pwm_out,
    output logic              match_evt
);

    logic             run;
    logic             hit;
    logic             ld_cmp;
    logic             flip_tbit;
    logic             busy;
    svc_state_t       svc_state;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cmp_q;

    assign run = tmr_en && (ctl_mode == MODE_PWM) && ctl_tgl_sel;

    ctpwm_timer #(.CNT_W(CNT_W)) u_timer (
        .clk (clk),
        .rst (rst),
        .en  (tmr_en),
        .cnt (cnt_q)
    );

    ctpwm_svc_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .hit       (hit),
        .ld_cmp    (ld_cmp),
        .flip_tbit (flip_tbit),
        .busy      (busy),
        .state     (svc_state)
    );

    ctpwm_cmp_path #(.CNT_W(CNT_W)) u_path (
        .clk       (clk),
        .rst       (rst),
        .run       (run),
        .busy      (busy),
        .ld_cmp    (ld_cmp),
        .flip_tbit (flip_tbit),
        .cnt       (cnt_q),
        .cmp_start (cmp_start),
        .inc_lo    (inc_lo),
        .inc_hi    (inc_hi),
        .tbit_init (ctl_tbit_init),
        .hit       (hit),
        .tbit      (tbit_live),
        .cmp       (cmp_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pwm_out   <= 1'b1;
            match_evt <= 1'b0;
        end else begin
            match_evt <= hit;
            if (hit) begin
                pwm_out <= ~pwm_out;
            end
        end
    end

endmodule

// File: rtl/ctpwm_checker.sv
module ctpwm_checker
    import ctpwm_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             tmr_en,
    input logic             run,
    input logic             pwm_out,
    input logic             match_evt,
    input logic             tbit_live,
    input logic [CNT_W-1:0] cnt_q,
    input logic [CNT_W-1:0] cmp_q,
    input logic [CNT_W-1:0] inc_lo,
    input logic [CNT_W-1:0] inc_hi
);

    p_evt_flips_pwm_r1: assert property (@(posedge clk) disable iff (rst)
        (match_evt && !$past(rst)) |-> (pwm_out != $past(pwm_out)));

    p_quiet_pwm_r1: assert property (@(posedge clk) disable iff (rst)
        (!match_evt && !$past(rst)) |-> $stable(pwm_out));

    p_evt_single_r1: assert property (@(posedge clk) disable iff (rst)
        match_evt |=> !match_evt);

    p_cmp_advance_r2: assert property (@(posedge clk) disable iff (rst)
        match_evt |=> (cmp_q == $past(cmp_q) +
                       ($past(tbit_live) ? $past(inc_hi) : $past(inc_lo))));

    p_tbit_flip_r3: assert property (@(posedge clk) disable iff (rst)
        match_evt |-> ##2 (tbit_live != $past(tbit_live, 2)));

    p_gated_off_r8: assert property (@(posedge clk) disable iff (rst)
        !run |=> !match_evt);

    p_timer_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (!tmr_en && !$past(rst)) |=> $stable(cnt_q));

endmodule

bind cmp_toggle_pwm ctpwm_checker #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .tmr_en    (tmr_en),
    .run       (run),
    .pwm_out   (pwm_out),
    .match_evt (match_evt),
    .tbit_live (tbit_live),
    .cnt_q     (cnt_q),
    .cmp_q     (cmp_q),
    .inc_lo    (inc_lo),
    .inc_hi    (inc_hi)
);

// File: tb/cmp_toggle_pwm_bench.sv
module cmp_toggle_pwm_bench;

    typedef struct packed {
        logic [15:0] start;
        logic [15:0] lo;
        logic [15:0] hi;
        logic        init;
    } vec_t;

    localparam int NV = 5;
    localparam int NINT = 6;
    localparam vec_t VEC [NV] = '{
        '{start: 16'd10,     lo: 16'd5,  hi: 16'd7,  init: 1'b1},
        '{start: 16'd3,      lo: 16'd4,  hi: 16'd9,  init: 1'b0},
        '{start: 16'hFFF0,   lo: 16'd6,  hi: 16'd20, init: 1'b1},
        '{start: 16'd100,    lo: 16'd3,  hi: 16'd3,  init: 1'b1},
        '{start: 16'd40,     lo: 16'd12, hi: 16'd4,  init: 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tmr_en = 1'b0;
    logic [2:0]  ctl_mode = 3'b010;
    logic        ctl_tgl_sel = 1'b1;
    logic        ctl_tbit_init = 1'b1;
    logic [15:0] cmp_start = 16'd10;
    logic [15:0] inc_lo = 16'd5;
    logic [15:0] inc_hi = 16'd5;
    logic        tbit_live;
    logic        pwm_out;
    logic        match_evt;

    int n_vec = 0;
    int n_bad = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    cmp_toggle_pwm u_cmp_toggle_pwm (
        .clk           (clk),
        .rst           (rst),
        .tmr_en        (tmr_en),
        .ctl_mode      (ctl_mode),
        .ctl_tgl_sel   (ctl_tgl_sel),
        .ctl_tbit_init (ctl_tbit_init),
        .cmp_start     (cmp_start),
        .inc_lo        (inc_lo),
        .inc_hi        (inc_hi),
        .tbit_live     (tbit_live),
        .pwm_out       (pwm_out),
        .match_evt     (match_evt)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic apply_reset();
        @(negedge clk);
        rst = 1'b1;
        tmr_en = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    // counts negedges until match_evt is seen, up to lim
    task automatic wait_evt(input int lim, output int n);
        n = 0;
        for (int i = 0; i < lim; i++) begin
            @(negedge clk);
            n++;
            if (match_evt) return;
        end
        n = -1;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000 && !done) begin
                done = 1'b1;
                n_vec++;
                n_bad++;
                $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
                $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
                $finish;
            end
        end
    end

    initial begin
        int n;
        int exp_gap;
        bit tb;
        bit pwm_prev;

        // vector table: full periods per entry
        for (int v = 0; v < NV; v++) begin
            ctl_mode      = 3'b010;
            ctl_tgl_sel   = 1'b1;
            cmp_start     = VEC[v].start;
            inc_lo        = VEC[v].lo;
            inc_hi        = VEC[v].hi;
            ctl_tbit_init = VEC[v].init;
            apply_reset();
            // R4: reset state
            chk(pwm_out == 1'b1, "R4 pwm after reset", int'(pwm_out), 1);
            chk(tbit_live == VEC[v].init, "R4 tbit after reset", int'(tbit_live), int'(VEC[v].init));
            rst = 1'b0;
            tmr_en = 1'b1;
            wait_evt(70000, n);
            // R5: first event timing and level; R10 for the wrapping entry
            chk(n == int'(VEC[v].start) + 1, "R5 first event time", n, int'(VEC[v].start) + 1);
            chk(pwm_out == 1'b0, "R5 first match drives low", int'(pwm_out), 0);
            for (int j = 1; j <= NINT; j++) begin
                tb = VEC[v].init ^ 1'(((j - 1) & 1));
                exp_gap = tb ? int'(VEC[v].hi) : int'(VEC[v].lo);
                pwm_prev = pwm_out;
                n = 0;
                for (int k = 0; k < 70000; k++) begin
                    @(negedge clk);
                    n++;
                    if (n == 2) begin
                        // R3: live toggle bit inverted two clocks after event
                        chk(tbit_live == ~tb, "R3 live toggle bit", int'(tbit_live), int'(~tb));
                    end
                    if (!match_evt && pwm_out != pwm_prev) begin
                        chk(1'b0, "R1 output changed without event", int'(pwm_out), int'(pwm_prev));
                    end
                    if (match_evt) break;
                end
                // R2/R6/R7/R10: interval equals chosen increment
                chk(n == exp_gap, VEC[v].init ? "R6 interval" : "R7 interval", n, exp_gap);
                chk(pwm_out == ~pwm_prev, "R1 output toggles on event", int'(pwm_out), int'(~pwm_prev));
            end
        end

        // directed: R8 wrong mode code
        ctl_mode = 3'b011;
        ctl_tgl_sel = 1'b1;
        cmp_start = 16'd5;
        inc_lo = 16'd4;
        inc_hi = 16'd4;
        ctl_tbit_init = 1'b1;
        apply_reset();
        rst = 1'b0;
        tmr_en = 1'b1;
        wait_evt(40, n);
        chk(n == -1, "R8 no event with mode 3'b011", n, -1);
        chk(pwm_out == 1'b1, "R8 output held with wrong mode", int'(pwm_out), 1);

        // directed: R8 toggle-mode select cleared
        ctl_mode = 3'b010;
        ctl_tgl_sel = 1'b0;
        apply_reset();
        rst = 1'b0;
        tmr_en = 1'b1;
        wait_evt(40, n);
        chk(n == -1, "R8 no event with select 0", n, -1);
        chk(pwm_out == 1'b1, "R8 output held with select 0", int'(pwm_out), 1);
        chk(tbit_live == 1'b1, "R8 toggle bit untouched", int'(tbit_live), 1);

        // directed: R9 disable window stretches one interval
        ctl_tgl_sel = 1'b1;
        cmp_start = 16'd20;
        inc_lo = 16'd8;
        inc_hi = 16'd8;
        apply_reset();
        rst = 1'b0;
        tmr_en = 1'b1;
        wait_evt(100, n);
        chk(n == 21, "R9 first event before disable", n, 21);
        n = 0;
        repeat (3) begin
            @(negedge clk);
            n++;
        end
        tmr_en = 1'b0;
        pwm_prev = pwm_out;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            n++;
            if (match_evt || pwm_out != pwm_prev) begin
                chk(1'b0, "R9 activity while disabled", int'(pwm_out), int'(pwm_prev));
            end
        end
        chk(pwm_out == pwm_prev, "R9 output held while disabled", int'(pwm_out), int'(pwm_prev));
        tmr_en = 1'b1;
        for (int k = 0; k < 200; k++) begin
            @(negedge clk);
            n++;
            if (match_evt) break;
        end
        chk(n == 48, "R9 interval stretched by disabled clocks", n, 48);
        chk(pwm_out == 1'b1, "R9 second match drives high", int'(pwm_out), 1);

        // directed: R4 reset with initial toggle bit 0
        ctl_tbit_init = 1'b0;
        apply_reset();
        chk(tbit_live == 1'b0, "R4 toggle bit loads 0", int'(tbit_live), 0);
        chk(match_evt == 1'b0, "R4 no event in reset", int'(match_evt), 0);
        chk(pwm_out == 1'b1, "R4 output high in reset", int'(pwm_out), 1);

        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule